// File: doc/BRIEF.md
# Serial EEPROM Page Stager and Word Pointer

This block sits between the bit-level front end of a two-wire serial EEPROM and its array write controller. It holds the internal word pointer and a staging buffer one page wide (16 bytes by default). The front end reports, with single-cycle pulses, that an address was received, that a data byte was accepted in a write transfer, that a byte was delivered in a read transfer, or that a stop condition was seen. The block turns these pulses into pointer moves, buffer fills and a single commit request.

While a write transfer runs, each accepted byte goes into the buffer slot named by the low pointer bits. Only those low bits step, so the pointer stays inside the page. When a stop arrives and at least one byte was staged, the block raises a one-cycle commit request. The request carries the page base address, all buffer bytes and a byte-valid mask. During reads the same pointer steps across the whole array and wraps from the top address to zero. A current-address read therefore fetches the location after the last one accessed, and a random read uses the address left by a dummy write that carried no data.

Top module: `eeprom_page_stager`

## Requirements
- R1: After reset, `next_addr` is 0 and `commit_valid` is low.
- R2: An `addr_load` pulse sets `next_addr`, from the next cycle, to `{blk_sel, word_addr}` truncated to its low `ADDR_W` bits. It also discards any staged bytes (the mask becomes all zero).
- R3: A `byte_valid` pulse (without `addr_load`) stores `byte_in` in slot `next_addr[3:0]` and marks that slot valid. It then adds one to `next_addr[3:0]` modulo 16 and leaves the upper bits unchanged.
- R4: If more than 16 bytes arrive before a stop, the pointer wraps inside the page, and a later byte replaces the earlier byte held in the same slot.
- R5: A `stop_seen` pulse while at least one slot is valid raises `commit_valid` for exactly the following cycle. In that cycle `commit_base` is `next_addr` with its low 4 bits cleared, bit i of `commit_mask` is set only for slots written since the last clear, and byte i of `commit_data` (bits 8i+7..8i) holds the last byte written to slot i.
- R6: A `stop_seen` pulse with no valid slot (for example after a write transfer that carried only the address) raises no commit.
- R7: A `read_step` pulse (without `addr_load` or `byte_valid`) adds one to `next_addr` modulo 2^`ADDR_W`, so the top address wraps to 0.
- R8: Every stop clears the mask, so a second stop with no new bytes raises no commit, and `commit_valid` never stays high for two cycles in a row.
- R9: When several pulses come in the same cycle, `addr_load` takes priority over `byte_valid`, and `byte_valid` takes priority over `read_step`. Only the winning pulse moves the pointer.
- R10: In a cycle with none of `addr_load`, `byte_valid` or `read_step`, `next_addr` keeps its value. After a write to address n, `next_addr` therefore reads n+1 (within the page) for a following current-address read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | Pulse: word address received |
| blk_sel | input | BLK_BITS | Block-select bits from the device address byte |
| word_addr | input | 8 | Word-address byte |
| byte_valid | input | 1 | Pulse: data byte accepted in a write transfer |
| byte_in | input | DATA_W | Data byte to stage |
| read_step | input | 1 | Pulse: one byte delivered in a read transfer |
| stop_seen | input | 1 | Pulse: stop condition seen on the bus |
| next_addr | output | ADDR_W | Word pointer, the next address to fetch or write |
| commit_valid | output | 1 | One-cycle page commit request |
| commit_base | output | ADDR_W | Page-aligned base address of the commit |
| commit_data | output | PAGE_BYTES*DATA_W | Staged bytes, slot i in bits 8i+7..8i |
| commit_mask | output | PAGE_BYTES | Per-slot valid mask of the commit |

## Verification
The bench targets the in-page wrap during writes. A design that carried into the upper bits would move the pointer onto the next page and report the wrong commit base. It also overfills a page with twenty bytes. A design that ignored the wrap, or kept the first byte written to a slot, would show stale bytes in the low slots. It checks the top-of-array wrap on reads, where a page-confined step would return to the start of the page instead of to 0. It also checks stops with an empty buffer and repeated stops, where a design that kept its mask would commit the same page twice. Finally it drives simultaneous pulses to confirm that a load wins.

// File: rtl/eps_pkg.sv
package eps_pkg;

    typedef enum logic [1:0] {
        OP_HOLD       = 2'd0,
        OP_LOAD       = 2'd1,
        OP_PAGE_STEP  = 2'd2,
        OP_ARRAY_STEP = 2'd3
    } ptr_op_e;

    // Pointer move selected by the front-end pulses; load wins, then write, then read.
    function automatic ptr_op_e pick_op(input logic load, input logic wr, input logic rd);
        if (load)    return OP_LOAD;
        else if (wr) return OP_PAGE_STEP;
        else if (rd) return OP_ARRAY_STEP;
        else         return OP_HOLD;
    endfunction

endpackage

// File: rtl/eps_addr_ctr.sv
module eps_addr_ctr
    import eps_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ptr_op_e           op,
    input  logic [ADDR_W-1:0] load_value,
    output logic [ADDR_W-1:0] ptr
);

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_LOAD:       st_d.ptr = load_value;
            OP_PAGE_STEP:  st_d.ptr = {st_q.ptr[ADDR_W-1:PAGE_W], st_q.ptr[PAGE_W-1:0] + 1'b1};
            OP_ARRAY_STEP: st_d.ptr = st_q.ptr + 1'b1;
            default:       st_d.ptr = st_q.ptr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr = st_q.ptr;

endmodule

// File: rtl/eps_page_buf.sv
module eps_page_buf #(
    parameter int PAGE_BYTES = 16,
    parameter int DATA_W     = 8,
    localparam int PAGE_W    = $clog2(PAGE_BYTES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         wr_en,
    input  logic [PAGE_W-1:0]            wr_idx,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [PAGE_BYTES*DATA_W-1:0] data_flat,
    output logic [PAGE_BYTES-1:0]        mask
);

    typedef struct packed {
        logic [PAGE_BYTES-1:0][DATA_W-1:0] data;
        logic [PAGE_BYTES-1:0]             mask;
    } buf_t;

    buf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) st_d.mask = '0;
        if (wr_en) begin
            st_d.data[wr_idx] = wr_data;
            st_d.mask[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_flat = st_q.data;
    assign mask      = st_q.mask;

endmodule

// File: rtl/eps_commit_stage.sv
module eps_commit_stage #(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BYTES = 16,
    parameter int DATA_W     = 8,
    localparam int PAGE_W    = $clog2(PAGE_BYTES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         snap,
    input  logic [ADDR_W-1:0]            ptr,
    input  logic [PAGE_BYTES*DATA_W-1:0] data_in,
    input  logic [PAGE_BYTES-1:0]        mask_in,
    output logic                         valid,
    output logic [ADDR_W-1:0]            base,
    output logic [PAGE_BYTES*DATA_W-1:0] data_out,
    output logic [PAGE_BYTES-1:0]        mask_out
);

    typedef struct packed {
        logic                         valid;
        logic [ADDR_W-1:0]            base;
        logic [PAGE_BYTES*DATA_W-1:0] data;
        logic [PAGE_BYTES-1:0]        mask;
    } cmt_t;

    cmt_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (snap && (|mask_in)) begin
            st_d.valid = 1'b1;
            st_d.base  = {ptr[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};
            st_d.data  = data_in;
            st_d.mask  = mask_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid    = st_q.valid;
    assign base     = st_q.base;
    assign data_out = st_q.data;
    assign mask_out = st_q.mask;

endmodule

// File: rtl/eeprom_page_stager.sv
module eeprom_page_stager
    import eps_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int BLK_BITS   = 3,
    parameter int PAGE_BYTES = 16,
    parameter int DATA_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         addr_load,
    input  logic [BLK_BITS-1:0]          blk_sel,
    input  logic [7:0]                   word_addr,
    input  logic                         byte_valid,
    input  logic [DATA_W-1:0]            byte_in,
    input  logic                         read_step,
    input  logic                         stop_seen,
    output logic [ADDR_W-1:0]            next_addr,
    output logic                         commit_valid,
    output logic [ADDR_W-1:0]            commit_base,
    output logic [PAGE_BYTES*DATA_W-1:0] commit_data,
    output logic [PAGE_BYTES-1:0]        commit_mask
);

    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int FULL_W = BLK_BITS + 8;

    logic [FULL_W-1:0]            full_addr;
    logic [ADDR_W-1:0]            load_value;
    ptr_op_e                      op;
    logic [ADDR_W-1:0]            ptr;
    logic [PAGE_BYTES*DATA_W-1:0] buf_data;
    logic [PAGE_BYTES-1:0]        buf_mask;
    logic                         wr_take;
    logic                         buf_clear;

    always_comb begin
        full_addr  = {blk_sel, word_addr};
        load_value = full_addr[ADDR_W-1:0];
        op         = pick_op(addr_load, byte_valid, read_step);
        wr_take    = (op == OP_PAGE_STEP);
        buf_clear  = stop_seen | addr_load;
    end

    eps_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .load_value (load_value),
        .ptr        (ptr)
    );

    eps_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (buf_clear),
        .wr_en     (wr_take),
        .wr_idx    (ptr[PAGE_W-1:0]),
        .wr_data   (byte_in),
        .data_flat (buf_data),
        .mask      (buf_mask)
    );

    eps_commit_stage #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_cmt (
        .clk      (clk),
        .rst_n    (rst_n),
        .snap     (stop_seen),
        .ptr      (ptr),
        .data_in  (buf_data),
        .mask_in  (buf_mask),
        .valid    (commit_valid),
        .base     (commit_base),
        .data_out (commit_data),
        .mask_out (commit_mask)
    );

    assign next_addr = ptr;

endmodule

// File: rtl/eps_stager_chk.sv
module eps_stager_chk #(
    parameter int ADDR_W     = 11,
    parameter int BLK_BITS   = 3,
    parameter int PAGE_BYTES = 16,
    localparam int PAGE_W    = $clog2(PAGE_BYTES),
    localparam int FULL_W    = BLK_BITS + 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  addr_load,
    input logic [BLK_BITS-1:0]   blk_sel,
    input logic [7:0]            word_addr,
    input logic                  byte_valid,
    input logic                  read_step,
    input logic                  stop_seen,
    input logic [ADDR_W-1:0]     next_addr,
    input logic                  commit_valid,
    input logic [ADDR_W-1:0]     commit_base,
    input logic [PAGE_BYTES-1:0] commit_mask
);

    logic [FULL_W-1:0] req_full;
    assign req_full = {blk_sel, word_addr};

    AST_LOAD_SETS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |=> next_addr == $past(req_full[ADDR_W-1:0])); // R2

    AST_PAGE_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !addr_load) |=> next_addr[ADDR_W-1:PAGE_W] == $past(next_addr[ADDR_W-1:PAGE_W])); // R3

    AST_PAGE_LOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !addr_load) |=> next_addr[PAGE_W-1:0] == $past(next_addr[PAGE_W-1:0]) + 1'b1); // R3

    AST_ARRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (read_step && !addr_load && !byte_valid) |=> next_addr == $past(next_addr) + 1'b1); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!read_step && !addr_load && !byte_valid) |=> $stable(next_addr)); // R10

    AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_seen |=> !commit_valid); // R5

    AST_COMMIT_HAS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> (commit_mask != '0) && (commit_base[PAGE_W-1:0] == '0)); // R5

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |=> !commit_valid); // R8

endmodule

bind eeprom_page_stager eps_stager_chk #(
    .ADDR_W(ADDR_W), .BLK_BITS(BLK_BITS), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_load    (addr_load),
    .blk_sel      (blk_sel),
    .word_addr    (word_addr),
    .byte_valid   (byte_valid),
    .read_step    (read_step),
    .stop_seen    (stop_seen),
    .next_addr    (next_addr),
    .commit_valid (commit_valid),
    .commit_base  (commit_base),
    .commit_mask  (commit_mask)
);

// File: tb/tb_eeprom_page_stager.sv
module tb_eeprom_page_stager;

    localparam int ADDR_W = 11;
    localparam int BLK_BITS = 3;
    localparam int PB = 16;
    localparam int DW = 8;
    localparam int SIZE = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_load = 1'b0;
    logic [BLK_BITS-1:0] blk_sel = '0;
    logic [7:0] word_addr = '0;
    logic byte_valid = 1'b0;
    logic [DW-1:0] byte_in = '0;
    logic read_step = 1'b0;
    logic stop_seen = 1'b0;
    logic [ADDR_W-1:0] next_addr;
    logic commit_valid;
    logic [ADDR_W-1:0] commit_base;
    logic [PB*DW-1:0] commit_data;
    logic [PB-1:0] commit_mask;

    always #5 clk = ~clk;

    eeprom_page_stager #(.ADDR_W(ADDR_W), .BLK_BITS(BLK_BITS), .PAGE_BYTES(PB), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .blk_sel(blk_sel),
        .word_addr(word_addr), .byte_valid(byte_valid), .byte_in(byte_in),
        .read_step(read_step), .stop_seen(stop_seen), .next_addr(next_addr),
        .commit_valid(commit_valid), .commit_base(commit_base),
        .commit_data(commit_data), .commit_mask(commit_mask)
    );

    // Behavioural reference
    int m_ptr = 0;
    logic [7:0] m_buf [PB];
    logic [PB-1:0] m_mask = '0;
    logic e_valid = 1'b0;
    int e_base = 0;
    logic [PB-1:0] e_mask = '0;
    logic [7:0] e_data [PB];

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ptr = 0; m_mask = '0; e_valid = 1'b0;
        end else begin
            e_valid = 1'b0;
            if (stop_seen) begin
                if (m_mask != 0) begin
                    e_valid = 1'b1;
                    e_base = m_ptr - (m_ptr % PB);
                    e_mask = m_mask;
                    for (int i = 0; i < PB; i++) e_data[i] = m_buf[i];
                end
                m_mask = '0;
            end
            if (addr_load) begin
                m_ptr = ((int'(blk_sel) * 256) + int'(word_addr)) % SIZE;
                m_mask = '0;
            end else if (byte_valid) begin
                m_buf[m_ptr % PB] = byte_in;
                m_mask[m_ptr % PB] = 1'b1;
                m_ptr = (m_ptr - (m_ptr % PB)) + ((m_ptr + 1) % PB);
            end else if (read_step) begin
                m_ptr = (m_ptr + 1) % SIZE;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_req, "next_addr", int'(next_addr), m_ptr);
            check(cur_req, "commit_valid", int'(commit_valid), int'(e_valid));
            if (e_valid && commit_valid) begin
                check(cur_req, "commit_base", int'(commit_base), e_base);
                check(cur_req, "commit_mask", int'(commit_mask), int'(e_mask));
                for (int i = 0; i < PB; i++)
                    if (e_mask[i]) check(cur_req, "commit_data byte", int'(commit_data[i*8 +: 8]), int'(e_data[i]));
            end
        end
    end

    task automatic step(input logic ld, input int blk, input int wa,
                        input logic wr, input int b, input logic rd, input logic st);
        @(negedge clk);
        addr_load = ld; blk_sel = blk[BLK_BITS-1:0]; word_addr = wa[7:0];
        byte_valid = wr; byte_in = b[7:0]; read_step = rd; stop_seen = st;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        // R1: reset values
        check("R1", "reset next_addr", int'(next_addr), 0);
        check("R1", "reset commit_valid", int'(commit_valid), 0);

        cur_req = "R2";
        step(1, 5, 8'h3C, 0, 0, 0, 0);
        idle(1);
        check("R2", "loaded addr", int'(next_addr), 'h53C);

        cur_req = "R3";  // in-page wrap 0x53C..0x53F then 0x530, 0x531
        for (int k = 0; k < 6; k++) step(0, 0, 0, 1, 'hA0 + k, 0, 0);
        idle(1);
        check("R3", "page wrap addr", int'(next_addr), 'h532);
        cur_req = "R5";
        step(0, 0, 0, 0, 0, 0, 1);
        idle(1);
        cur_req = "R8";
        step(0, 0, 0, 0, 0, 0, 1);
        idle(2);

        cur_req = "R6";  // address-only write then stop
        step(1, 2, 8'h40, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1);
        idle(2);

        cur_req = "R4";  // overfill a page
        step(1, 1, 8'h20, 0, 0, 0, 0);
        for (int k = 0; k < 20; k++) step(0, 0, 0, 1, 'h10 + k, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1);
        idle(2);

        cur_req = "R7";  // top-of-array wrap
        step(1, 7, 8'hFE, 0, 0, 0, 0);
        for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 0, 1, 0);
        idle(1);
        check("R7", "array wrap addr", int'(next_addr), 2);

        cur_req = "R9";  // simultaneous pulses
        step(1, 3, 8'h11, 1, 'h55, 1, 0);
        step(0, 0, 0, 1, 'h66, 1, 0);
        step(1, 0, 8'h05, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0, 0, 1);
        idle(2);

        cur_req = "R10"; // write at 0x205, pointer then names 0x206 and holds
        step(1, 2, 8'h05, 0, 0, 0, 0);
        step(0, 0, 0, 1, 'h77, 0, 0);
        idle(4);
        check("R10", "addr after write", int'(next_addr), 'h206);
        step(0, 0, 0, 0, 0, 0, 1);
        idle(3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule